// File: doc/BRIEF.md
# DMA Channel Trigger and Completion Control

This block holds the control state of one channel of a DMA engine that is tied to an interrupt source. A channel can start in two ways. A hardware start happens when the channel's interrupt factor flag is set while both its request bit and its enable bit are armed. A software start happens on a single-cycle pulse. In both cases the block presents a start request to a separate transfer datapath and then waits for that datapath's done pulse. When the done pulse arrives, it decrements the transfer counter. It then settles the factor flag, the completion flag, the request bit, the enable bit and the interrupt output. How it settles them depends on the kind of start, on whether the counter has reached zero, and on whether the completion interrupt is enabled.

Software reaches the control bits, the counter and the flags through a simple register write port and a combinational read port. The start request is a valid/ready pair. `xfer_valid` rises one cycle after the start is accepted internally. It stays high, and the channel stays in the issue phase, for as long as the datapath holds `xfer_ready` low. The request is taken on the first clock edge where both signals are high. After that, the channel waits for `xfer_done`. A done pulse has effect only after the request has been taken.

Top module: `dma_trig_ctl`

## Requirements
- R1: After reset, every register reads zero: the control bits, the counter and the flags. The channel is idle, and `xfer_valid` and `irq` are low.
- R2: A hardware start needs four things: the factor flag set, request bit (control bit 0) = 1, enable bit (control bit 1) = 1, and an idle channel. A factor event sets the flag at one edge, the start is taken at the next edge, and `xfer_valid` is high after that edge. If either armed bit is 0, no transfer starts.
- R3: A software pulse starts a transfer only on an idle channel, and `xfer_valid` is high after the edge that samples the pulse. A pulse on a busy channel is ignored.
- R4: If a software pulse and a factor event arrive in the same cycle on an idle channel, the software transfer runs. The factor flag then waits as a pending hardware request.
- R5: `xfer_valid` stays high until a clock edge where `xfer_ready` is high. A done pulse before that edge is ignored.
- R6: Each done pulse decrements the counter by one, saturating at 0. The zero test uses the decremented value. A counter write while the channel is busy is ignored.
- R7: Hardware start, counter 0 after done, completion interrupt enable (control bit 2) = 1: the factor flag stays set, the request bit clears, the enable bit stays 1, and `irq` goes high.
- R8: Hardware start, counter nonzero after done: the factor flag clears, the request and enable bits stay 1, and `irq` stays low.
- R9: Hardware start, counter 0 after done, completion interrupt enable = 0: the factor flag clears, the request bit stays 1, the enable bit clears, and `irq` stays low.
- R10: Software transfer done: the factor flag clears, so any pending hardware request is dropped and never runs. The completion flag (status bit 1) sets only when the counter is 0 and the completion interrupt is enabled. The request and enable bits are unchanged. Starting a software transfer never sets the completion flag.
- R11: During a hardware transfer the factor flag stays set. A software clear of the flag is ignored during that time.
- R12: `irq` is high when the completion flag is set, or when the factor flag is set with the request bit at 0 on an idle channel.
- R13: The register map has three addresses. Address 0 is control: {enable completion interrupt, enable, request} in bits 2..0. Address 1 is the counter. Address 2 is status: {busy, completion, factor} in bits 2..0. Writing 1 to a status bit clears that flag. A completion event takes priority over a register write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Write address |
| reg_wdata | input | CNT_W | Write data |
| reg_raddr | input | 2 | Read address |
| reg_rdata | output | CNT_W | Read data (combinational) |
| sw_trig | input | 1 | Software start pulse |
| fac_evt | input | 1 | Interrupt factor event, sets the factor flag |
| xfer_valid | output | 1 | Start request to the transfer datapath |
| xfer_ready | input | 1 | Datapath accepts the start request |
| xfer_done | input | 1 | Datapath finished one transfer |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the three hardware completion outcomes. A design that mixes them up would fire an interrupt on a nonzero count, or leave the enable bit set when the interrupt is disabled. It also targets a factor event that lands during a software transfer or in the same cycle as its start. If that event were not dropped at completion, a second, hardware-started transfer would follow. The bench also covers a done pulse that arrives before the start is taken, a counter that starts at zero and must not wrap, and counter writes and software pulses made while the channel is busy. A design that accepted any of these would show a wrong count, or extra or early `xfer_valid` cycles.

// File: rtl/dmact_pkg.sv
package dmact_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } dmact_state_e;

  localparam logic [1:0] RA_CTRL  = 2'd0;
  localparam logic [1:0] RA_COUNT = 2'd1;
  localparam logic [1:0] RA_STAT  = 2'd2;

  localparam int CB_REQ  = 0;
  localparam int CB_EN   = 1;
  localparam int CB_CIE  = 2;
  localparam int SB_FAC  = 0;
  localparam int SB_CMP  = 1;
  localparam int SB_BUSY = 2;
  localparam int FIELD_W = 3;

endpackage

// File: rtl/dmact_seq.sv
module dmact_seq
  import dmact_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sw_trig,
  input  logic hw_ready,
  input  logic xfer_ready,
  input  logic xfer_done,
  output logic xfer_valid,
  output logic idle,
  output logic hw_busy,
  output logic by_sw,
  output logic done_evt
);

  dmact_state_e state_q, state_d;
  logic by_sw_q, by_sw_d;

  always_comb begin
    state_d = state_q;
    by_sw_d = by_sw_q;
    unique case (state_q)
      ST_IDLE: begin
        if (sw_trig) begin
          state_d = ST_ISSUE;
          by_sw_d = 1'b1;
        end else if (hw_ready) begin
          state_d = ST_ISSUE;
          by_sw_d = 1'b0;
        end
      end
      ST_ISSUE: if (xfer_ready) state_d = ST_WAIT;
      ST_WAIT:  if (xfer_done)  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      by_sw_q <= 1'b0;
    end else begin
      state_q <= state_d;
      by_sw_q <= by_sw_d;
    end
  end

  assign xfer_valid = (state_q == ST_ISSUE);
  assign idle       = (state_q == ST_IDLE);
  assign hw_busy    = !idle && !by_sw_q;
  assign by_sw      = by_sw_q;
  assign done_evt   = (state_q == ST_WAIT) && xfer_done;

  // R5: request held until taken
  a_r5_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_ready |=> xfer_valid);

  // R3: a start is only ever taken from idle
  a_r3_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_valid) |-> $past(state_q == ST_IDLE));

endmodule

// File: rtl/dmact_cnt.sv
module dmact_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle,
  input  logic             wr_cnt,
  input  logic [CNT_W-1:0] wdata,
  input  logic             done_evt,
  output logic [CNT_W-1:0] cnt_q,
  output logic             zero_after
);

  logic [CNT_W-1:0] dec;

  assign dec        = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
  assign zero_after = (dec == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (done_evt)       cnt_q <= dec;
    else if (wr_cnt && idle) cnt_q <= wdata;
  end

  // R6: no wrap below zero
  a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt && (cnt_q == '0) |=> cnt_q == '0);

  // R6: counter untouched while busy and not completing
  a_r6_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !idle && !done_evt |=> $stable(cnt_q));

endmodule

// File: rtl/dmact_flags.sv
module dmact_flags
  import dmact_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_wr,
  input  logic               stat_wr,
  input  logic [FIELD_W-1:0] wfield,
  input  logic               fac_evt,
  input  logic               done_evt,
  input  logic               by_sw,
  input  logic               zero_after,
  input  logic               hw_busy,
  input  logic               idle,
  output logic               fac_q,
  output logic               cmp_q,
  output logic               req_q,
  output logic               en_q,
  output logic               cie_q,
  output logic               hw_ready,
  output logic               irq
);

  logic fac_d, cmp_d, req_d, en_d, cie_d;

  always_comb begin
    fac_d = fac_q;
    cmp_d = cmp_q;
    req_d = req_q;
    en_d  = en_q;
    cie_d = cie_q;
    if (stat_wr && wfield[SB_FAC] && !hw_busy) fac_d = 1'b0;
    if (stat_wr && wfield[SB_CMP])             cmp_d = 1'b0;
    if (fac_evt)                               fac_d = 1'b1;
    if (ctrl_wr) begin
      req_d = wfield[CB_REQ];
      en_d  = wfield[CB_EN];
      cie_d = wfield[CB_CIE];
    end
    if (done_evt) begin
      if (by_sw) begin
        fac_d = 1'b0;
        if (zero_after && cie_q) cmp_d = 1'b1;
      end else if (zero_after && cie_q) begin
        fac_d = 1'b1;
        req_d = 1'b0;
        en_d  = 1'b1;
      end else if (!zero_after) begin
        fac_d = 1'b0;
        req_d = 1'b1;
        en_d  = 1'b1;
      end else begin
        fac_d = 1'b0;
        req_d = 1'b1;
        en_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fac_q <= 1'b0;
      cmp_q <= 1'b0;
      req_q <= 1'b0;
      en_q  <= 1'b0;
      cie_q <= 1'b0;
    end else begin
      fac_q <= fac_d;
      cmp_q <= cmp_d;
      req_q <= req_d;
      en_q  <= en_d;
      cie_q <= cie_d;
    end
  end

  assign hw_ready = fac_q && req_q && en_q;
  assign irq      = cmp_q || (fac_q && !req_q && idle);

  // R11: factor flag held through a hardware transfer
  a_r11_fac_held: assert property (@(posedge clk) disable iff (!rst_n)
    hw_busy |-> fac_q);

  // R10: software completion drops the factor flag
  a_r10_sw_fac_clr: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt && by_sw |=> !fac_q);

  // R9: disabled completion interrupt clears enable, keeps request
  a_r9_en_clr: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt && !by_sw && zero_after && !cie_q |=> !en_q && req_q && !fac_q);

  // R7: enabled completion interrupt raises irq through the factor flag
  a_r7_irq_up: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt && !by_sw && zero_after && cie_q |=> irq && !req_q && en_q);

endmodule

// File: rtl/dma_trig_ctl.sv
module dma_trig_ctl
  import dmact_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_waddr,
  input  logic [CNT_W-1:0] reg_wdata,
  input  logic [1:0]       reg_raddr,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic             sw_trig,
  input  logic             fac_evt,
  output logic             xfer_valid,
  input  logic             xfer_ready,
  input  logic             xfer_done,
  output logic             irq
);

  localparam int DW = CNT_W;

  logic idle, hw_busy, by_sw, done_evt, hw_ready, zero_after;
  logic fac_q, cmp_q, req_q, en_q, cie_q;
  logic [CNT_W-1:0] cnt_q;
  logic ctrl_wr, cnt_wr, stat_wr;

  assign ctrl_wr = reg_wr && (reg_waddr == RA_CTRL);
  assign cnt_wr  = reg_wr && (reg_waddr == RA_COUNT);
  assign stat_wr = reg_wr && (reg_waddr == RA_STAT);

  dmact_seq i_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_trig    (sw_trig),
    .hw_ready   (hw_ready),
    .xfer_ready (xfer_ready),
    .xfer_done  (xfer_done),
    .xfer_valid (xfer_valid),
    .idle       (idle),
    .hw_busy    (hw_busy),
    .by_sw      (by_sw),
    .done_evt   (done_evt)
  );

  dmact_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .idle       (idle),
    .wr_cnt     (cnt_wr),
    .wdata      (reg_wdata),
    .done_evt   (done_evt),
    .cnt_q      (cnt_q),
    .zero_after (zero_after)
  );

  dmact_flags i_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .stat_wr    (stat_wr),
    .wfield     (reg_wdata[FIELD_W-1:0]),
    .fac_evt    (fac_evt),
    .done_evt   (done_evt),
    .by_sw      (by_sw),
    .zero_after (zero_after),
    .hw_busy    (hw_busy),
    .idle       (idle),
    .fac_q      (fac_q),
    .cmp_q      (cmp_q),
    .req_q      (req_q),
    .en_q       (en_q),
    .cie_q      (cie_q),
    .hw_ready   (hw_ready),
    .irq        (irq)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (reg_raddr)
      RA_CTRL: begin
        reg_rdata[CB_REQ] = req_q;
        reg_rdata[CB_EN]  = en_q;
        reg_rdata[CB_CIE] = cie_q;
      end
      RA_COUNT: reg_rdata = cnt_q[DW-1:0];
      RA_STAT: begin
        reg_rdata[SB_FAC]  = fac_q;
        reg_rdata[SB_CMP]  = cmp_q;
        reg_rdata[SB_BUSY] = !idle;
      end
      default: reg_rdata = '0;
    endcase
  end

  // R12: no interrupt while a hardware transfer owns the factor flag
  a_r12_no_irq_hw: assert property (@(posedge clk) disable iff (!rst_n)
    hw_busy && !cmp_q |-> !irq);

endmodule

// File: tb/test_dma_trig_ctl.sv
module test_dma_trig_ctl;

  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_waddr = '0;
  logic [CNT_W-1:0] reg_wdata = '0;
  logic [1:0] reg_raddr = '0;
  logic [CNT_W-1:0] reg_rdata;
  logic sw_trig = 1'b0, fac_evt = 1'b0;
  logic xfer_valid;
  logic xfer_ready = 1'b0, xfer_done = 1'b0;
  logic irq;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dma_trig_ctl #(.CNT_W(CNT_W)) i_dma_trig_ctl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .sw_trig(sw_trig), .fac_evt(fac_evt), .xfer_valid(xfer_valid),
    .xfer_ready(xfer_ready), .xfer_done(xfer_done), .irq(irq)
  );

  typedef struct packed {
    logic [CNT_W-1:0] cnt;
    logic fac, cmp, req, en, irq;
  } exp_t;

  function automatic exp_t expect_after(bit sw, bit rq, bit en, bit cie, int unsigned cnt);
    exp_t e;
    logic z;
    e.cnt = (cnt == 0) ? '0 : CNT_W'(cnt - 1);
    z = (e.cnt == '0);
    e.req = rq; e.en = en; e.fac = 1'b0; e.cmp = 1'b0;
    if (sw) e.cmp = z && cie;
    else if (z && cie) begin e.fac = 1'b1; e.req = 1'b0; end
    else if (z) e.en = 1'b0;
    e.irq = e.cmp || (e.fac && !e.req);
    return e;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [CNT_W-1:0] d);
    reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
    cyc();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [CNT_W-1:0] d);
    reg_raddr = a; #1; d = reg_rdata;
  endtask

  task automatic at_neg();
    @(negedge clk);
  endtask

  task automatic do_xfer(input bit sw, input bit rq, input bit en, input bit cie,
                         input int unsigned cnt, input bit same_cyc, input bit inj_fac,
                         input bit stray, input bit wr_busy, input bit sw_busy,
                         input int vdelay, input int ddelay);
    logic [CNT_W-1:0] d;
    exp_t e;
    wr(2'd0, '0);
    wr(2'd2, CNT_W'(3));
    wr(2'd0, CNT_W'({cie, en, rq}));
    wr(2'd1, CNT_W'(cnt));
    if (sw) begin
      sw_trig = 1'b1; fac_evt = same_cyc;
      cyc();
      sw_trig = 1'b0; fac_evt = 1'b0;
      at_neg();
      chk("R3 sw start latency", xfer_valid, 1);
    end else begin
      fac_evt = 1'b1;
      cyc();
      fac_evt = 1'b0;
      at_neg();
      chk("R2 no start before flag registered", xfer_valid, 0);
      if (!(rq && en)) begin
        for (int i = 0; i < 3; i++) begin cyc(); at_neg(); chk("R2 unarmed no start", xfer_valid, 0); end
        rd(2'd2, d);
        chk("R2 flag set, idle", d[2:0], 3'b001);
        chk("R12 irq plain factor", irq, !rq);
        return;
      end
      cyc(); at_neg();
      chk("R2 hw start latency", xfer_valid, 1);
    end
    cyc();
    for (int i = 0; i < vdelay; i++) begin
      xfer_done = stray && (i == 0);
      cyc();
      xfer_done = 1'b0;
      at_neg();
      chk("R5 valid held", xfer_valid, 1);
      cyc();
    end
    xfer_ready = 1'b1;
    cyc();
    xfer_ready = 1'b0;
    at_neg();
    chk("R5 valid drops after accept", xfer_valid, 0);
    cyc();
    rd(2'd2, d);
    chk("R13 busy bit", d[2], 1);
    if (!sw) begin
      wr(2'd2, CNT_W'(1));
      rd(2'd2, d);
      chk("R11 factor flag held", d[0], 1);
    end
    if (inj_fac && sw) begin fac_evt = 1'b1; cyc(); fac_evt = 1'b0; end
    if (wr_busy) wr(2'd1, CNT_W'(77));
    if (sw_busy) begin sw_trig = 1'b1; cyc(); sw_trig = 1'b0; end
    if (sw) begin rd(2'd2, d); chk("R10 no completion flag at sw start", d[1], 0); end
    for (int i = 0; i < ddelay; i++) cyc();
    xfer_done = 1'b1;
    cyc();
    xfer_done = 1'b0;
    e = expect_after(sw, rq, en, cie, cnt);
    at_neg();
    rd(2'd1, d);
    chk("R6 counter after done", d, e.cnt);
    rd(2'd2, d);
    chk(sw ? "R10 status after sw" : (e.fac ? "R7 status" : (e.en ? "R8 status" : "R9 status")),
        d[2:0], {1'b0, e.cmp, e.fac});
    rd(2'd0, d);
    chk(sw ? "R10 ctrl unchanged" : (e.fac ? "R7 ctrl" : (e.en ? "R8 ctrl" : "R9 ctrl")),
        d[2:0], {cie, e.en, e.req});
    chk("R12 irq after done", irq, e.irq);
    for (int i = 0; i < 4; i++) begin
      cyc(); at_neg();
      chk(sw ? "R4 pending dropped, no start" : "R3 no restart", xfer_valid, 0);
    end
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [CNT_W-1:0] d;
    void'($urandom(32'h1d3a5));
    repeat (3) cyc();
    at_neg();
    chk("R1 valid after reset", xfer_valid, 0);
    chk("R1 irq after reset", irq, 0);
    rd(2'd0, d); chk("R1 ctrl zero", d, 0);
    rd(2'd1, d); chk("R1 count zero", d, 0);
    rd(2'd2, d); chk("R1 status zero", d, 0);
    rst_n = 1'b1;
    cyc();
    // directed corners
    do_xfer(0, 1, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0);  // R7
    do_xfer(0, 1, 1, 1, 3, 0, 0, 0, 0, 0, 1, 2);  // R8
    do_xfer(0, 1, 1, 0, 1, 0, 0, 0, 0, 0, 0, 1);  // R9
    do_xfer(0, 1, 1, 1, 0, 0, 0, 1, 1, 1, 2, 0);  // R6 saturation, stray done, busy writes
    do_xfer(1, 1, 1, 1, 1, 1, 0, 0, 0, 0, 0, 0);  // R4 simultaneous
    do_xfer(1, 1, 1, 0, 1, 0, 1, 0, 0, 1, 1, 1);  // R10 pending dropped, cie off
    do_xfer(1, 0, 0, 1, 2, 0, 0, 0, 1, 0, 0, 0);  // R10 nonzero
    do_xfer(0, 0, 1, 1, 2, 0, 0, 0, 0, 0, 0, 0);  // R2 request off
    do_xfer(0, 1, 0, 1, 2, 0, 0, 0, 0, 0, 0, 0);  // R2 enable off
    for (int k = 0; k < 150; k++) begin
      bit sw, rq, en;
      sw = $urandom_range(0, 1) == 1;
      rq = sw ? ($urandom_range(0, 1) == 1) : ($urandom_range(0, 4) != 0);
      en = sw ? ($urandom_range(0, 1) == 1) : ($urandom_range(0, 4) != 0);
      do_xfer(sw, rq, en, $urandom_range(0, 1) == 1, $urandom_range(0, 3),
              $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
              $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
              $urandom_range(0, 1) == 1, $urandom_range(0, 3), $urandom_range(0, 3));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule